// File: doc/BRIEF.md
# Half-Duplex Backpressure Jam Controller

This block gives a half-duplex MAC a way to stop a remote station from sending while the local receive buffer is nearly full. It compares the buffer fill level with a programmable threshold and with the full level. When either limit is reached, the block arms. It then lets any transmission already under way finish. After that it waits for the next frame to begin arriving on the medium. When that frame starts, it requests a jam from the transmit path, which causes a collision and makes the sender back off.

The jam is started only on the first cycle of a newly arriving frame. A frame that is already in progress is never jammed, so the block cannot cause a late collision. While the buffer stays above its limit, the jam continues so that other stations keep deferring. The jam data is a fixed 32-bit pattern of alternating ones and zeros. A jam always ends at the end of a complete pattern. In full-duplex mode the block does nothing.

Top module: `hdx_backpressure_jam`

## Requirements
- R1: Out of reset, `jam_o` and `jam_bit_o` are 0. The carrier input is treated as already high at reset, so a frame that is present when reset is released does not count as a new frame start.
- R2: The block arms when `half_dup_i` is 1 and `fill_lvl_i >= thresh_i`. A fill level one below the threshold does not arm it.
- R3: While armed, if `tx_busy_i` is 1, no jam starts until `tx_busy_i` has been observed 0. A frame that starts during that wait does not trigger a jam.
- R4: Once armed with the transmitter idle, a 0-to-1 transition of `crs_i` makes `jam_o` go high in the next cycle.
- R5: A frame whose carrier was already high when the block entered its wait state is not jammed. Only a later 0-to-1 transition of `crs_i` triggers a jam.
- R6: While `jam_o` is 1, `jam_bit_o` follows a 32-bit pattern that starts at 1 and alternates every cycle. While `jam_o` is 0, `jam_bit_o` is 0.
- R7: As long as the block remains armed, the jam continues past the first pattern.
- R8: Once the block is disarmed, the current pattern is completed before `jam_o` goes low. As a result, the total jam length is a multiple of 32 cycles. A disarm before the jam starts returns the block to idle at once.
- R9: When `half_dup_i` is 0, no jam starts, whatever the fill level and carrier activity.
- R10: A fill level at or above the full level (2048 by default) arms the block even when the threshold is set higher than that.
- R11: If the transmitter goes idle in the same cycle that a frame starts, that frame counts as already in progress and is not jammed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_dup_i | input | 1 | 1 selects half-duplex operation |
| fill_lvl_i | input | LVL_W (12) | Receive buffer fill level |
| thresh_i | input | LVL_W (12) | Arming threshold |
| tx_busy_i | input | 1 | A local transmission is in progress |
| crs_i | input | 1 | Carrier / receive frame active on the medium |
| jam_o | output | 1 | Jam request to the transmit path |
| jam_bit_o | output | 1 | Serial jam pattern bit |

## Verification
Two events can fall in the same cycle: the end of the drain wait (the transmitter going idle) and the start of a frame. The bench provokes this directly by dropping `tx_busy_i` and raising `crs_i` on the same edge. It then expects no jam for that frame, but a jam on the next rising carrier. Random traffic also produces disarms that land exactly on a pattern boundary or in the middle of a pattern. Every cycle is compared against a bench reference model of the arm, drain, wait and jam rules.

// File: rtl/bp_jam_pkg.sv
package bp_jam_pkg;
  typedef enum logic [1:0] {
    BP_IDLE,
    BP_DRAIN,
    BP_WAIT_SOF,
    BP_JAM
  } bp_state_e;
endpackage

// File: rtl/bp_arm_detect.sv
module bp_arm_detect #(
  parameter int LVL_W    = 12,
  parameter int FULL_LVL = 2048
) (
  input  logic             half_dup_i,
  input  logic [LVL_W-1:0] fill_lvl_i,
  input  logic [LVL_W-1:0] thresh_i,
  output logic             arm_o
);
  localparam logic [LVL_W-1:0] FullL = LVL_W'(FULL_LVL);

  logic over_thr, at_full;

  assign over_thr = fill_lvl_i >= thresh_i;
  assign at_full  = fill_lvl_i >= FullL;
  assign arm_o    = half_dup_i & (over_thr | at_full);
endmodule

// File: rtl/bp_sof_detect.sv
module bp_sof_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic crs_i,
  output logic sof_o
);
  logic crs_q;

  // reset high: a frame present at reset release is treated as in progress
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crs_q <= 1'b1;
    else         crs_q <= crs_i;
  end

  assign sof_o = crs_i & ~crs_q;
endmodule

// File: rtl/bp_jam_gen.sv
module bp_jam_gen #(
  parameter int                 PAT_LEN     = 32,
  parameter logic [PAT_LEN-1:0] JAM_PATTERN = {(PAT_LEN/2){2'b01}}
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic bit_o,
  output logic last_o
);
  localparam int CNT_W = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;
  localparam logic [CNT_W-1:0] LastIdx = CNT_W'(PAT_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_inc;

  generate
    if ((PAT_LEN & (PAT_LEN - 1)) == 0) begin : g_pow2
      assign cnt_inc = cnt_q + 1'b1;
    end else begin : g_mod
      assign cnt_inc = (cnt_q == LastIdx) ? '0 : cnt_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_inc;
  end

  assign last_o = cnt_q == LastIdx;
  assign bit_o  = JAM_PATTERN[cnt_q];
endmodule

// File: rtl/hdx_backpressure_jam.sv
module hdx_backpressure_jam
  import bp_jam_pkg::*;
#(
  parameter int                 LVL_W       = 12,
  parameter int                 FULL_LVL    = 2048,
  parameter int                 PAT_LEN     = 32,
  parameter logic [PAT_LEN-1:0] JAM_PATTERN = {(PAT_LEN/2){2'b01}}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             half_dup_i,
  input  logic [LVL_W-1:0] fill_lvl_i,
  input  logic [LVL_W-1:0] thresh_i,
  input  logic             tx_busy_i,
  input  logic             crs_i,
  output logic             jam_o,
  output logic             jam_bit_o
);
  bp_state_e state_q, state_d;
  logic      arm, sof, pat_bit, pat_last, jam_start;

  bp_arm_detect #(.LVL_W(LVL_W), .FULL_LVL(FULL_LVL)) u_arm (
    .half_dup_i (half_dup_i),
    .fill_lvl_i (fill_lvl_i),
    .thresh_i   (thresh_i),
    .arm_o      (arm)
  );

  bp_sof_detect u_sof (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .crs_i  (crs_i),
    .sof_o  (sof)
  );

  bp_jam_gen #(.PAT_LEN(PAT_LEN), .JAM_PATTERN(JAM_PATTERN)) u_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (jam_start),
    .run_i   (jam_o),
    .bit_o   (pat_bit),
    .last_o  (pat_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BP_IDLE:     if (arm) state_d = tx_busy_i ? BP_DRAIN : BP_WAIT_SOF;
      BP_DRAIN:    if (!arm) state_d = BP_IDLE;
                   else if (!tx_busy_i) state_d = BP_WAIT_SOF;
      BP_WAIT_SOF: if (!arm) state_d = BP_IDLE;
                   else if (sof) state_d = BP_JAM;
      BP_JAM:      if (pat_last && !arm) state_d = BP_IDLE;
      default:     state_d = BP_IDLE;
    endcase
  end

  assign jam_start = (state_q == BP_WAIT_SOF) && (state_d == BP_JAM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= BP_IDLE;
    else         state_q <= state_d;
  end

  assign jam_o     = state_q == BP_JAM;
  assign jam_bit_o = jam_o & pat_bit;
endmodule

// File: rtl/hdx_backpressure_jam_chk.sv
module hdx_backpressure_jam_chk #(
  parameter int LVL_W    = 12,
  parameter int FULL_LVL = 2048,
  parameter int PAT_LEN  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             half_dup_i,
  input logic [LVL_W-1:0] fill_lvl_i,
  input logic [LVL_W-1:0] thresh_i,
  input logic             crs_i,
  input logic             jam_o,
  input logic             jam_bit_o
);
  localparam int CW = $clog2(PAT_LEN) + 1;
  logic          armed_in;
  logic [CW-1:0] run_cnt;

  assign armed_in = half_dup_i &&
                    (fill_lvl_i >= thresh_i || fill_lvl_i >= LVL_W'(FULL_LVL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    run_cnt <= '0;
    else if (jam_o) run_cnt <= (run_cnt == CW'(PAT_LEN - 1)) ? '0 : run_cnt + 1'b1;
    else            run_cnt <= '0;
  end

  // R4
  jam_on_sof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(jam_o) |-> $past(crs_i) && !$past(crs_i, 2));
  // R6
  jam_alternate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jam_o && $past(jam_o) |-> jam_bit_o != $past(jam_bit_o));
  // R6
  jam_bit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !jam_o |-> !jam_bit_o);
  // R8
  jam_end_disarmed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(jam_o) |-> !$past(armed_in));
  // R8
  jam_whole_pattern_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(jam_o) |-> run_cnt == '0);
  // R9
  full_duplex_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_dup_i && !jam_o |=> !jam_o);
endmodule

bind hdx_backpressure_jam hdx_backpressure_jam_chk #(
  .LVL_W(LVL_W), .FULL_LVL(FULL_LVL), .PAT_LEN(PAT_LEN)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .half_dup_i (half_dup_i),
  .fill_lvl_i (fill_lvl_i),
  .thresh_i   (thresh_i),
  .crs_i      (crs_i),
  .jam_o      (jam_o),
  .jam_bit_o  (jam_bit_o)
);

// File: tb/hdx_backpressure_jam_tb.sv
module hdx_backpressure_jam_tb;
  localparam int LVL_W = 12;
  localparam int FULL  = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hd = 1'b1, tx = 1'b0, crs = 1'b0;
  logic [LVL_W-1:0] fill = '0, thr = 12'd100;
  logic jam, jbit;
  int n_chk = 0, n_fail = 0;

  // reference model
  int m_mode = 0;  // 0 idle, 1 drain, 2 wait, 3 jam
  int m_cnt  = 0;
  bit m_prev = 1'b1;

  always #2 clk = ~clk;

  hdx_backpressure_jam u_dut (
    .clk_i(clk), .rst_ni(rst_n), .half_dup_i(hd), .fill_lvl_i(fill),
    .thresh_i(thr), .tx_busy_i(tx), .crs_i(crs), .jam_o(jam), .jam_bit_o(jbit)
  );

  function automatic bit armed(bit h, int f, int t);
    return h && (f >= t || f >= FULL);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_update();
    bit a, s;
    if (!rst_n) begin m_mode = 0; m_cnt = 0; m_prev = 1'b1; return; end
    a = armed(hd, int'(fill), int'(thr));
    s = crs && !m_prev;
    case (m_mode)
      0: if (a) m_mode = tx ? 1 : 2;
      1: if (!a) m_mode = 0; else if (!tx) m_mode = 2;
      2: if (!a) m_mode = 0; else if (s) begin m_mode = 3; m_cnt = 0; end
      default: begin
        if (m_cnt == 31) begin m_cnt = 0; if (!a) m_mode = 0; end
        else m_cnt++;
      end
    endcase
    m_prev = crs;
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk("R4 model jam_o", jam, m_mode == 3);
    chk("R6 model jam_bit_o", jbit, (m_mode == 3) && (m_cnt % 2 == 0));
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drop_jam();
    fill = '0;
    for (int i = 0; i < 80 && jam; i++) step();
    crs = 1'b0; tx = 1'b0;
    steps(2);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    crs = 1'b1;
    rst_n = 1'b1;
    step();
    chk("R1 jam_o after reset", jam, 1'b0);
    chk("R1 jam_bit_o after reset", jbit, 1'b0);
    // frame present at reset release, armed: no jam
    fill = 12'd200; steps(3);
    chk("R1 frame at reset not jammed", jam, 1'b0);
    fill = '0; crs = 1'b0; steps(2);

    // R2 threshold boundary
    fill = 12'd99; steps(2);
    crs = 1'b1; step();
    chk("R2 below threshold no jam", jam, 1'b0);
    crs = 1'b0; step();
    fill = 12'd100; step();
    crs = 1'b1; step();
    chk("R2 at threshold jams", jam, 1'b1);
    chk("R6 first jam bit is 1", jbit, 1'b1);
    n = 1;
    step(); n++;
    chk("R6 second jam bit is 0", jbit, 1'b0);
    for (int i = 0; i < 39; i++) begin step(); if (jam) n++; end
    chk("R7 jam held while armed", jam, 1'b1);
    fill = 12'd50;
    while (jam) begin step(); if (jam) n++; end
    chk("R8 jam length 64", n == 64, 1'b1);
    crs = 1'b0; steps(2);

    // R3 drain
    tx = 1'b1; fill = 12'd100; step();
    crs = 1'b1; step(); crs = 1'b0; step();
    chk("R3 no jam while tx busy", jam, 1'b0);
    crs = 1'b1; step();
    chk("R3 no jam while tx busy 2", jam, 1'b0);
    crs = 1'b0; tx = 1'b0; step();
    crs = 1'b1; step();
    chk("R3 jam after tx idle", jam, 1'b1);
    drop_jam();

    // R5 frame in progress
    crs = 1'b1; steps(2);
    fill = 12'd100; steps(3);
    chk("R5 in-progress frame not jammed", jam, 1'b0);
    crs = 1'b0; step(); crs = 1'b1; step();
    chk("R5 next frame jammed", jam, 1'b1);
    drop_jam();

    // R11 tx end and frame start in same cycle
    fill = 12'd100; tx = 1'b1; step();
    tx = 1'b0; crs = 1'b1; steps(3);
    chk("R11 coincident frame not jammed", jam, 1'b0);
    crs = 1'b0; step(); crs = 1'b1; step();
    chk("R11 following frame jammed", jam, 1'b1);
    drop_jam();

    // R8 disarm before jam: immediate idle
    fill = 12'd100; steps(2); fill = '0; step();
    crs = 1'b1; step();
    chk("R8 disarmed wait returns idle", jam, 1'b0);
    crs = 1'b0; step();

    // R9 full duplex
    hd = 1'b0; fill = 12'd2000;
    for (int i = 0; i < 6; i++) begin crs = ~crs; step(); end
    chk("R9 full duplex no jam", jam, 1'b0);
    crs = 1'b0; fill = '0; hd = 1'b1; steps(2);

    // R10 full level
    thr = 12'd4000; fill = 12'd2047; step(); crs = 1'b1; step();
    chk("R10 below full no jam", jam, 1'b0);
    crs = 1'b0; fill = 12'd2048; step(); crs = 1'b1; step();
    chk("R10 full level jams", jam, 1'b1);
    drop_jam();

    // random traffic against the model
    thr = 12'd150;
    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(0, 39) == 0)  fill = 12'(150 + $urandom_range(0, 40) - 20);
      if ($urandom_range(0, 299) == 0) thr  = 12'($urandom_range(50, 300));
      if ($urandom_range(0, 15) == 0)  crs  = ~crs;
      if ($urandom_range(0, 24) == 0)  tx   = ~tx;
      if ($urandom_range(0, 599) == 0) hd   = ~hd;
      if ($urandom_range(0, 999) == 0) fill = 12'(FULL + $urandom_range(0, 5));
      step();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule